// File: doc/BRIEF.md
# Indirect Packet-Buffer Window

This block lets a microcontroller reach a 1024-byte packet buffer without mapping it into its own address space. The host sees a few byte registers: a setup register, two pointer registers and a data port. It loads a 10-bit address through the two pointer registers, and then moves bytes through the data port. An optional step mode advances the address after every byte, so a whole packet can be streamed with repeated accesses to one offset.

Reads are served from a holding register that is filled ahead of time. Host cycles therefore never wait for the buffer. Data-port writes are latched into the same holding register and committed to the buffer later. A second on-chip requester shares the buffer's single port through an arbiter. When both sides request, the arbiter alternates between them. A setup bit halves the rate at which the arbiter may grant.

Top module: `seqbuf_access`

## Requirements
- R1: After reset, the registers at offsets 1, 2, 3 and 4 all read 00h, the pointer is 000h and `aux_rdata` is 00h.
- R2: A write to offset 2 only stages its fields, and the staged value has no effect until offset 3 is written. Offset 2 holds bit 7 = direction (1 read, 0 write), bit 6 = step enable and bits 1:0 = address bits 9:8. Offsets 2 and 3 keep reading the active pointer and mode.
- R3: A write to offset 3 sets the pointer to {staged bits 9:8, written byte} and makes the staged direction and step bits active. In read direction it starts a prefetch. With no contention and slow arbitration off, a data-port read made after one idle clock returns the byte at that address.
- R4: In read direction with step enabled, each read of offset 4 returns the held byte, advances the pointer by one, and prefetches the next byte.
- R5: In write direction, a write to offset 4 stores the byte at the pointer. With step enabled, the pointer then advances by one.
- R6: With step disabled, data-port accesses leave the pointer unchanged. Repeated reads return the same byte, and repeated writes overwrite the same location.
- R7: The direction can change only through a pointer load. A data-port write in read direction changes neither the buffer, the holding register nor the pointer. A data-port read in write direction does not move the pointer.
- R8: Stepping past address 3FFh wraps the pointer to 000h.
- R9: The active pointer can be read back at any time: bits 9:8 at offset 2 bits 1:0, together with the active mode bits 7 and 6, and bits 7:0 at offset 3.
- R10: The arbiter grants at most one requester per clock and grants only a requester that is asking. When both ask, the one not granted last time wins.
- R11: Setup bit 0 at offset 1 enables slow arbitration. While it is set, grants occur at most every other clock, so a requester that asks continuously is granted in exactly 5 of any 10 consecutive clocks.
- R12: The second requester writes the buffer in its grant clock when `aux_we` is 1. When `aux_we` is 0, it receives the byte at `aux_addr` on `aux_rdata` from the clock after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (side effects at offset 4) |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr` |
| aux_req | input | 1 | Second requester asks for the buffer |
| aux_we | input | 1 | Second requester access is a write |
| aux_addr | input | 10 | Second requester buffer address |
| aux_wdata | input | 8 | Second requester write data |
| aux_gnt | output | 1 | Second requester is granted this clock |
| aux_rdata | output | 8 | Byte read by the second requester |

## Verification
The buffer is filled through the data port with step on, and read back with step on and with step off. Comparing these runs shows whether the pointer advances on a read or on a commit, and whether the prefetch lands before the host reads. Other patterns cover direction misuse, staging of the high pointer, and the wrap at 3FFh. Each of these is compared against pointer readback, to separate a wrong address from wrong data. A continuously requesting second port is used in two ways: counting its missed grants around a host load exposes the alternation rule, and counting its grants with slow arbitration on exposes the halved grant rate.

// File: rtl/seqbuf_pkg.sv
// Shared register offsets for the indirect buffer window.
// Assumes a 3-bit host register offset.
package seqbuf_pkg;
    localparam int REG_AW = 3;
    localparam logic [REG_AW-1:0] OFS_SETUP  = 3'h1;
    localparam logic [REG_AW-1:0] OFS_PTR_HI = 3'h2;
    localparam logic [REG_AW-1:0] OFS_PTR_LO = 3'h3;
    localparam logic [REG_AW-1:0] OFS_DATA   = 3'h4;
endpackage

// File: rtl/seqbuf_mem.sv
// Single-port byte buffer: combinational read, synchronous write.
// Assumes the caller has already muxed address and data for one user per clock.
// The contents are not reset.
module seqbuf_mem #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Write the addressed byte.
    always_ff @(posedge clk) begin
        if (we) store[addr] <= wdata;
    end

    // Read the addressed byte.
    assign rdata = store[addr];
endmodule

// File: rtl/seqbuf_arb.sv
// Two-way buffer arbiter: alternating priority, optional half-rate granting.
// Assumes requests stay asserted until they are granted.
module seqbuf_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic slow,
    input  logic host_req,
    input  logic aux_req,
    output logic host_gnt,
    output logic aux_gnt
);
    logic phase;
    logic last_aux;
    logic elig;

    // Grants are allowed every clock, or on alternate clocks in slow mode.
    assign elig = !slow || phase;

    // Pick a winner; the side that lost last time goes first on a tie.
    always_comb begin
        host_gnt = elig && host_req && (!aux_req || last_aux);
        aux_gnt  = elig && aux_req && (!host_req || !last_aux);
    end

    // Track the slow phase and the most recent winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= 1'b0;
            last_aux <= 1'b0;
        end else begin
            phase <= slow ? !phase : 1'b0;
            if (host_gnt)     last_aux <= 1'b0;
            else if (aux_gnt) last_aux <= 1'b1;
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({host_gnt, aux_gnt})); // R10
    AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_gnt |-> host_req) and (aux_gnt |-> aux_req)); // R10
    AST_AUX_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(aux_gnt) && host_req && aux_req |-> !aux_gnt); // R10
    AST_HOST_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(host_gnt) && host_req && aux_req |-> !host_gnt); // R10
    AST_SLOW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        slow && $past(slow) && $past(host_gnt || aux_gnt) |-> !(host_gnt || aux_gnt)); // R11
endmodule

// File: rtl/seqbuf_regs.sv
// Host register window: setup, staged/active pointer, holding register,
// prefetch and write-back requests.
// Assumes the host reloads the pointer before it changes direction, and leaves
// one idle clock between a pointer load and the first data read.
module seqbuf_regs
    import seqbuf_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              host_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              host_req,
    output logic              host_we,
    output logic [ADDR_W-1:0] ptr,
    output logic [DATA_W-1:0] hold,
    output logic              slow
);
    localparam int HI_W    = ADDR_W - DATA_W;
    localparam int DIR_BIT = DATA_W - 1;
    localparam int INC_BIT = DATA_W - 2;
    localparam int PAD_W   = DATA_W - 2 - HI_W;
    localparam logic [ADDR_W-1:0] ONE = 1;

    logic [HI_W-1:0] hi_stage;
    logic            stage_dir, stage_inc;
    logic            act_dir, act_inc;
    logic            rd_pend, wr_pend;
    logic            wr_setup, wr_hi, wr_lo, wr_data, rd_data;

    // Decode host strobes per register.
    always_comb begin
        wr_setup = host_wr && (host_addr == OFS_SETUP);
        wr_hi    = host_wr && (host_addr == OFS_PTR_HI);
        wr_lo    = host_wr && (host_addr == OFS_PTR_LO);
        wr_data  = host_wr && (host_addr == OFS_DATA);
        rd_data  = host_rd && (host_addr == OFS_DATA);
    end

    // Register state: staging, pointer, holding byte and pending requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow      <= 1'b0;
            hi_stage  <= '0;
            stage_dir <= 1'b0;
            stage_inc <= 1'b0;
            act_dir   <= 1'b0;
            act_inc   <= 1'b0;
            ptr       <= '0;
            hold      <= '0;
            rd_pend   <= 1'b0;
            wr_pend   <= 1'b0;
        end else begin
            if (wr_setup) slow <= host_wdata[0];
            if (wr_hi) begin
                hi_stage  <= host_wdata[HI_W-1:0];
                stage_dir <= host_wdata[DIR_BIT];
                stage_inc <= host_wdata[INC_BIT];
            end
            if (host_gnt && wr_pend) begin
                wr_pend <= 1'b0;
                if (act_inc) ptr <= ptr + ONE;
            end else if (host_gnt && rd_pend) begin
                hold    <= mem_rdata;
                rd_pend <= 1'b0;
            end
            if (wr_lo) begin
                ptr     <= {hi_stage, host_wdata};
                act_dir <= stage_dir;
                act_inc <= stage_inc;
                rd_pend <= stage_dir;
            end
            if (rd_data && act_dir && act_inc) begin
                ptr     <= ptr + ONE;
                rd_pend <= 1'b1;
            end
            if (wr_data && !act_dir) begin
                hold    <= host_wdata;
                wr_pend <= 1'b1;
            end
        end
    end

    // Requests toward the arbiter; a pending write goes first.
    assign host_req = rd_pend || wr_pend;
    assign host_we  = wr_pend;

    // Host read mux over the register window.
    always_comb begin
        case (host_addr)
            OFS_SETUP:  host_rdata = {{(DATA_W-1){1'b0}}, slow};
            OFS_PTR_HI: host_rdata = {act_dir, act_inc, {PAD_W{1'b0}}, ptr[ADDR_W-1:DATA_W]};
            OFS_PTR_LO: host_rdata = ptr[DATA_W-1:0];
            OFS_DATA:   host_rdata = hold;
            default:    host_rdata = '0;
        endcase
    end

    AST_LOAD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> ptr == {$past(hi_stage), $past(host_wdata)}); // R3
    AST_STEP_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && act_dir && act_inc |=> ptr == $past(ptr) + ONE); // R4
    AST_BAD_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && act_dir && !wr_pend && !wr_lo |=> !wr_pend); // R7
    AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !act_inc && !wr_lo && (rd_data || wr_data) |=> $stable(ptr)); // R6
endmodule

// File: rtl/seqbuf_access.sv
// Top of the indirect buffer window: host registers, arbiter and byte buffer,
// plus the second requester's port.
// Assumes the second requester holds its request and address until granted.
module seqbuf_access
    import seqbuf_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              aux_req,
    input  logic              aux_we,
    input  logic [ADDR_W-1:0] aux_addr,
    input  logic [DATA_W-1:0] aux_wdata,
    output logic              aux_gnt,
    output logic [DATA_W-1:0] aux_rdata
);
    logic              host_req, host_we, host_gnt, slow;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] hold;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    seqbuf_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_gnt(host_gnt), .mem_rdata(mem_rdata),
        .host_req(host_req), .host_we(host_we),
        .ptr(ptr), .hold(hold), .slow(slow)
    );

    seqbuf_arb u_arb (
        .clk(clk), .rst_n(rst_n), .slow(slow),
        .host_req(host_req), .aux_req(aux_req),
        .host_gnt(host_gnt), .aux_gnt(aux_gnt)
    );

    // Steer the single buffer port to the granted side.
    always_comb begin
        mem_addr  = aux_gnt ? aux_addr : ptr;
        mem_wdata = aux_gnt ? aux_wdata : hold;
        mem_we    = (host_gnt && host_we) || (aux_gnt && aux_we);
    end

    seqbuf_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .we(mem_we), .addr(mem_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    // Capture the byte for a granted second-requester read.
    always_ff @(posedge clk) begin
        if (!rst_n)                  aux_rdata <= '0;
        else if (aux_gnt && !aux_we) aux_rdata <= mem_rdata;
    end

    AST_WRITE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (host_gnt || aux_gnt)); // R12
endmodule

// File: tb/seqbuf_access_tb.sv
module seqbuf_access_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       aux_req = 1'b0, aux_we = 1'b0;
    logic [9:0] aux_addr = '0;
    logic [7:0] aux_wdata = '0;
    logic       aux_gnt;
    logic [7:0] aux_rdata;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seqbuf_access u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .aux_req(aux_req), .aux_we(aux_we), .aux_addr(aux_addr),
        .aux_wdata(aux_wdata), .aux_gnt(aux_gnt), .aux_rdata(aux_rdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        host_addr = a;
        #1;
        check(host_rdata == exp, tag, host_rdata, exp);
    endtask

    task automatic rd_data(input logic [7:0] exp, input string tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = 3'h4;
        #1;
        check(host_rdata == exp, tag, host_rdata, exp);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic load(input logic [7:0] hi, input logic [7:0] lo);
        wr_reg(3'h2, hi);
        wr_reg(3'h3, lo);
    endtask

    task automatic t_reset();
        peek(3'h1, 8'h00, "R1 setup");
        peek(3'h2, 8'h00, "R1 ptr hi");
        peek(3'h3, 8'h00, "R1 ptr lo");
        peek(3'h4, 8'h00, "R1 data");
        check(aux_rdata == 8'h00, "R1 aux_rdata", aux_rdata, 0);
    endtask

    task automatic t_stage();
        wr_reg(3'h2, 8'h43);
        peek(3'h2, 8'h00, "R2 hi unchanged");
        peek(3'h3, 8'h00, "R2 lo unchanged");
    endtask

    task automatic t_fill();
        load(8'h41, 8'h10);
        peek(3'h2, 8'h41, "R9 hi readback");
        peek(3'h3, 8'h10, "R9 lo readback");
        for (int i = 0; i < 4; i++) wr_reg(3'h4, 8'hA0 + 8'(i));
        @(negedge clk);
        peek(3'h3, 8'h14, "R5 ptr advanced");
    endtask

    task automatic t_stream();
        load(8'hC1, 8'h10);
        for (int i = 0; i < 4; i++) rd_data(8'hA0 + 8'(i), "R3 R4 streamed byte");
        peek(3'h3, 8'h14, "R4 ptr after reads");
    endtask

    task automatic t_nostep();
        load(8'h81, 8'h12);
        rd_data(8'hA2, "R6 first read");
        rd_data(8'hA2, "R6 repeat read");
        peek(3'h3, 8'h12, "R6 ptr still");
        load(8'h01, 8'h12);
        wr_reg(3'h4, 8'h5A);
        wr_reg(3'h4, 8'h5B);
        @(negedge clk);
        load(8'h81, 8'h12);
        rd_data(8'h5B, "R6 overwrite same loc");
        load(8'h81, 8'h13);
        rd_data(8'hA3, "R6 neighbour intact");
    endtask

    task automatic t_dir();
        load(8'h81, 8'h12);
        wr_reg(3'h4, 8'h77);
        @(negedge clk);
        rd_data(8'h5B, "R7 hold unchanged");
        peek(3'h3, 8'h12, "R7 ptr unchanged by write");
        load(8'h81, 8'h12);
        rd_data(8'h5B, "R7 buffer unchanged");
        load(8'h41, 8'h20);
        rd_data(8'h5B, "R7 read in write dir");
        peek(3'h3, 8'h20, "R7 ptr unchanged by read");
    endtask

    task automatic t_wrap();
        load(8'h43, 8'hFF);
        wr_reg(3'h4, 8'h11);
        wr_reg(3'h4, 8'h22);
        @(negedge clk);
        peek(3'h2, 8'h40, "R8 hi after wrap");
        peek(3'h3, 8'h01, "R8 lo after wrap");
        load(8'hC3, 8'hFF);
        rd_data(8'h11, "R8 byte at 3FF");
        rd_data(8'h22, "R8 byte at 000");
    endtask

    task automatic t_aux();
        @(negedge clk);
        aux_req = 1'b1; aux_we = 1'b1; aux_addr = 10'h200; aux_wdata = 8'h99;
        #1;
        check(aux_gnt == 1'b1, "R12 aux write grant", aux_gnt, 1);
        @(negedge clk);
        aux_req = 1'b0; aux_we = 1'b0;
        load(8'h82, 8'h00);
        rd_data(8'h99, "R12 aux write seen by host");
        load(8'h02, 8'h01);
        wr_reg(3'h4, 8'h66);
        @(negedge clk);
        aux_req = 1'b1; aux_addr = 10'h201;
        #1;
        check(aux_gnt == 1'b1, "R12 aux read grant", aux_gnt, 1);
        @(negedge clk);
        aux_req = 1'b0;
        #1;
        check(aux_rdata == 8'h66, "R12 aux read data", aux_rdata, 8'h66);
    endtask

    task automatic t_arb();
        int misses = 0;
        wr_reg(3'h2, 8'h82);
        @(negedge clk);
        aux_req = 1'b1; aux_we = 1'b0; aux_addr = 10'h000;
        for (int i = 0; i < 5; i++) begin
            if (i > 0) @(negedge clk);
            host_wr = (i == 1); host_addr = 3'h3; host_wdata = 8'h00;
            #1;
            if (!aux_gnt) misses++;
        end
        host_wr = 1'b0;
        check(misses == 1, "R10 aux yields once", misses, 1);
        check(aux_rdata == 8'h22, "R12 continuous aux read", aux_rdata, 8'h22);
        @(negedge clk);
        aux_req = 1'b0;
        rd_data(8'h99, "R10 host prefetch under contention");
    endtask

    task automatic t_slow();
        int grants = 0;
        wr_reg(3'h1, 8'h01);
        peek(3'h1, 8'h01, "R11 setup readback");
        @(negedge clk);
        aux_req = 1'b1; aux_addr = 10'h000;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            #1;
            if (aux_gnt) grants++;
        end
        aux_req = 1'b0;
        check(grants == 5, "R11 half-rate grants", grants, 5);
        load(8'h82, 8'h01);
        repeat (3) @(negedge clk);
        rd_data(8'h66, "R11 slow prefetch");
        wr_reg(3'h1, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stage();
        t_fill();
        t_stream();
        t_nostep();
        t_dir();
        t_wrap();
        t_aux();
        t_arb();
        t_slow();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule